// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This controller decides when a volatile memory array is copied into its nonvolatile shadow (a store) and when the shadow is copied back (a recall). A store can be requested in three ways. The first is a falling edge on a shared active-low request pin. The second is a one-cycle software command. The third is a power-fail flag, which acts only while automatic storing is enabled. A recall runs by itself after reset, and it can also be requested from the idle state. The store and recall engines are modelled as fixed-length busy periods. The memory interface is told to hold off all accesses while either engine runs.

A dirty flag records whether the array has been written since the last completed store or recall. Stores from the pin and from power-fail are dropped when the flag is clear. Software stores always run. The shared pin is modelled as a pair of drive enables. The block pulls the pin low as a busy sign during every store. After a pin or software store it drives the pin high for a short time, and then releases it to the pull-up. All inputs are assumed to be synchronous to `clk`.

Top module: `nvseq_ctrl`

## Requirements
- R1: `access_inhibit` is high for exactly `STORE_CYC` cycles per store and `RECALL_CYC` cycles per recall. A `wr_strobe` that arrives while `access_inhibit` is high does not set the dirty flag.
- R2: During reset, `recall_start` and `access_inhibit` are high. `pin_drive_lo`, `pin_drive_hi` and `store_start` are low. After reset is released, `access_inhibit` stays high for `RECALL_CYC` cycles in total. Automatic storing is enabled and the dirty flag is clear.
- R3: In the idle state, a high-to-low change on `hw_pin_in` starts a wait of `DELAY_CYC` cycles. At the end of the wait a store starts only if the dirty flag is set. Writes made during the wait count toward the dirty flag. When the edge is sampled, `store_start` pulses `DELAY_CYC`+1 cycles later.
- R4: In the idle state, `pwr_fail` with automatic storing enabled starts a store on the next cycle if the dirty flag is set. Otherwise nothing happens. A store started this way is not followed by a high drive on the pin.
- R5: In the idle state, `sw_store_cmd` starts a store on the next cycle whatever the dirty flag holds.
- R6: `pin_drive_lo` is high for the `STORE_CYC` cycles of every store, and low at all other times.
- R7: After a store started from the pin or from the software command, `pin_drive_hi` is high for `HOLD_CYC` cycles, immediately after `pin_drive_lo` falls. `pin_drive_lo` and `pin_drive_hi` are never high together.
- R8: In the idle state, `recall_req` starts a recall on the next cycle. The dirty flag is clear after every completed store or recall.
- R9: A pulse on `auto_off_cmd` disables automatic storing until the next reset. After that, `pwr_fail` has no effect.
- R10: Every trigger that arrives while the block is not idle is discarded.
- R11: When `pwr_fail` (with automatic storing enabled) arrives in the same cycle as any other trigger, the other triggers are discarded. This holds even when the power-fail store itself is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_pin_in | input | 1 | Sampled level of the shared request/busy pin |
| sw_store_cmd | input | 1 | One-cycle software store command |
| pwr_fail | input | 1 | Supply-below-threshold flag |
| auto_off_cmd | input | 1 | One-cycle command that disables automatic storing |
| recall_req | input | 1 | Recall request |
| wr_strobe | input | 1 | One pulse per memory write |
| pin_drive_lo | output | 1 | Pull the shared pin low (busy during a store) |
| pin_drive_hi | output | 1 | Drive the shared pin high (post-store hold) |
| store_start | output | 1 | One-cycle start pulse to the store engine |
| recall_start | output | 1 | One-cycle start pulse to the recall engine |
| access_inhibit | output | 1 | Block memory reads and writes |

## Verification
A wrong dirty flag shows up at the first conditional trigger that follows it. A power-fail or pin store either starts or fails to start. The result can be seen on `store_start` one cycle after a power-fail, or `DELAY_CYC`+1 cycles after a pin edge. A wrong counter or state register shows up within a single operation, as a wrong number of cycles of `access_inhibit`, `pin_drive_lo` or `pin_drive_hi`. A broken priority or busy filter shows up at once, as a start pulse that should not appear or as a missing one.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  typedef enum logic [2:0] {
    ST_RECALL, ST_IDLE, ST_HWWAIT, ST_STORE, ST_HOLD
  } seq_state_t;

  typedef enum logic [2:0] {
    GO_NONE, GO_AUTO, GO_SW, GO_HW, GO_RCL
  } go_t;

  // Counter width that can hold the largest of four loaded values.
  function automatic int cnt_bits(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

  // Trigger priority: power-fail, then software, then pin edge, then recall.
  function automatic go_t pick_go(logic pf_ok, logic sw, logic hw_fall, logic rcl);
    if (pf_ok)        return GO_AUTO;
    else if (sw)      return GO_SW;
    else if (hw_fall) return GO_HW;
    else if (rcl)     return GO_RCL;
    else              return GO_NONE;
  endfunction

endpackage

// File: rtl/nvseq_timer.sv
module nvseq_timer #(
  parameter int W       = 4,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         zero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= W'(RST_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // Durations behind R6: the counter rests at zero and never wraps.
  p_timer_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);
endmodule

// File: rtl/nvseq_dirty.sv
module nvseq_dirty (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_strobe,
  input  logic inhibit,
  input  logic clear,
  output logic dirty
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      dirty <= 1'b0;
    else if (clear)                  dirty <= 1'b0;
    else if (wr_strobe && !inhibit)  dirty <= 1'b1;
  end

  p_wr_blocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !dirty) |=> !dirty);
endmodule

// File: rtl/nvseq_arbiter.sv
module nvseq_arbiter
  import nvseq_pkg::*;
(
  input  logic idle,
  input  logic auto_en,
  input  logic pwr_fail,
  input  logic sw_cmd,
  input  logic hw_fall,
  input  logic rcl_req,
  output go_t  go
);
  always_comb begin
    if (idle) go = pick_go(pwr_fail && auto_en, sw_cmd, hw_fall, rcl_req);
    else      go = GO_NONE;
  end
endmodule

// File: rtl/nvseq_ctrl.sv
module nvseq_ctrl
  import nvseq_pkg::*;
#(
  parameter int DELAY_CYC  = 4,
  parameter int STORE_CYC  = 8,
  parameter int RECALL_CYC = 6,
  parameter int HOLD_CYC   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_pin_in,
  input  logic sw_store_cmd,
  input  logic pwr_fail,
  input  logic auto_off_cmd,
  input  logic recall_req,
  input  logic wr_strobe,
  output logic pin_drive_lo,
  output logic pin_drive_hi,
  output logic store_start,
  output logic recall_start,
  output logic access_inhibit
);
  localparam int CW = cnt_bits(DELAY_CYC, STORE_CYC, RECALL_CYC, HOLD_CYC);
  localparam logic [CW-1:0] LD_DELAY  = CW'(DELAY_CYC - 1);
  localparam logic [CW-1:0] LD_STORE  = CW'(STORE_CYC - 1);
  localparam logic [CW-1:0] LD_RECALL = CW'(RECALL_CYC - 1);
  localparam logic [CW-1:0] LD_HOLD   = CW'(HOLD_CYC - 1);

  seq_state_t state, state_nxt;
  go_t        kind, kind_nxt, go;
  logic       auto_en, hw_prev, st_q, rc_q;
  logic       load, start_st, start_rc, dirty, tzero;
  logic [CW-1:0] load_val, cnt;

  // Named internal events
  logic idle, hw_fall, hw_fire, store_done, recall_done, clear_dirty;
  assign idle        = (state == ST_IDLE);
  assign hw_fall     = hw_prev && !hw_pin_in;
  assign hw_fire     = (state == ST_HWWAIT) && tzero;
  assign store_done  = (state == ST_STORE) && tzero;
  assign recall_done = (state == ST_RECALL) && tzero;
  assign clear_dirty = store_done || recall_done;

  nvseq_arbiter u_arb (
    .idle(idle), .auto_en(auto_en), .pwr_fail(pwr_fail), .sw_cmd(sw_store_cmd),
    .hw_fall(hw_fall), .rcl_req(recall_req), .go(go)
  );

  nvseq_timer #(.W(CW), .RST_VAL(RECALL_CYC - 1)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .cnt(cnt), .zero(tzero)
  );

  nvseq_dirty u_dirty (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .inhibit(access_inhibit),
    .clear(clear_dirty), .dirty(dirty)
  );

  always_comb begin
    state_nxt = state;
    kind_nxt  = kind;
    load      = 1'b0;
    load_val  = LD_STORE;
    start_st  = 1'b0;
    start_rc  = 1'b0;
    case (state)
      ST_IDLE: begin
        case (go)
          GO_AUTO: if (dirty) begin
            state_nxt = ST_STORE; load = 1'b1; start_st = 1'b1; kind_nxt = GO_AUTO;
          end
          GO_SW: begin
            state_nxt = ST_STORE; load = 1'b1; start_st = 1'b1; kind_nxt = GO_SW;
          end
          GO_HW: begin
            state_nxt = ST_HWWAIT; load = 1'b1; load_val = LD_DELAY;
          end
          GO_RCL: begin
            state_nxt = ST_RECALL; load = 1'b1; load_val = LD_RECALL; start_rc = 1'b1;
          end
          default: ;
        endcase
      end
      ST_HWWAIT: if (tzero) begin
        if (dirty) begin
          state_nxt = ST_STORE; load = 1'b1; start_st = 1'b1; kind_nxt = GO_HW;
        end else begin
          state_nxt = ST_IDLE;
        end
      end
      ST_STORE: if (tzero) begin
        if (kind == GO_AUTO) state_nxt = ST_IDLE;
        else begin
          state_nxt = ST_HOLD; load = 1'b1; load_val = LD_HOLD;
        end
      end
      ST_HOLD:   if (tzero) state_nxt = ST_IDLE;
      ST_RECALL: if (tzero) state_nxt = ST_IDLE;
      default:   state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_RECALL;
      kind    <= GO_NONE;
      auto_en <= 1'b1;
      hw_prev <= 1'b1;
      st_q    <= 1'b0;
      rc_q    <= 1'b1;
    end else begin
      state   <= state_nxt;
      kind    <= kind_nxt;
      hw_prev <= hw_pin_in;
      st_q    <= start_st;
      rc_q    <= start_rc;
      if (auto_off_cmd) auto_en <= 1'b0;
    end
  end

  assign store_start    = st_q;
  assign recall_start   = rc_q;
  assign pin_drive_lo   = (state == ST_STORE);
  assign pin_drive_hi   = (state == ST_HOLD);
  assign access_inhibit = (state == ST_STORE) || (state == ST_RECALL);

  p_start_inhibit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (store_start || recall_start) |-> access_inhibit);
  p_hw_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_fire && !dirty) |=> (!store_start && !access_inhibit));
  p_sw_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && sw_store_cmd && !(pwr_fail && auto_en)) |=> store_start);
  p_pin_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pin_drive_lo && pin_drive_hi));
  p_hold_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pin_drive_lo) && kind != GO_AUTO) |-> pin_drive_hi);
  p_clean_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(access_inhibit) |-> !dirty);
  p_auto_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> !auto_en);
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_STORE) && !tzero) |=> !recall_start);
  p_pf_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && pwr_fail && auto_en && !dirty) |=> (!store_start && !recall_start && idle));
endmodule

// File: tb/nvseq_ctrl_test.sv
module nvseq_ctrl_test;
  localparam int D = 4, SC = 8, RC = 6, H = 3;
  localparam int WIN = D + SC + H + RC + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_low = 1'b0, sw = 1'b0, pf = 1'b0, aoff = 1'b0, rq = 1'b0, wr = 1'b0;
  logic hw_pin, lo, hi, st, rc, inh;
  int checks = 0, errors = 0;
  int st_first, rc_first, n_st, n_rc, n_lo, n_hi, n_inh;

  always #5 clk = ~clk;
  assign hw_pin = ext_low ? 1'b0 : (lo ? 1'b0 : 1'b1);

  nvseq_ctrl #(.DELAY_CYC(D), .STORE_CYC(SC), .RECALL_CYC(RC), .HOLD_CYC(H)) uut (
    .clk(clk), .rst_n(rst_n), .hw_pin_in(hw_pin), .sw_store_cmd(sw), .pwr_fail(pf),
    .auto_off_cmd(aoff), .recall_req(rq), .wr_strobe(wr), .pin_drive_lo(lo),
    .pin_drive_hi(hi), .store_start(st), .recall_start(rc), .access_inhibit(inh)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Apply triggers for one edge, then watch WIN cycles. wr_k/rq_k: late pulses.
  task automatic fire(logic p, logic s, logic h, logic r, int wr_k, int rq_k);
    @(negedge clk);
    pf = p; sw = s; ext_low = h; rq = r;
    st_first = 0; rc_first = 0; n_st = 0; n_rc = 0; n_lo = 0; n_hi = 0; n_inh = 0;
    for (int k = 1; k <= WIN; k++) begin
      @(negedge clk);
      if (k == 1) begin pf = 0; sw = 0; ext_low = 0; rq = 0; end
      wr = (k == wr_k);
      if (k == rq_k) rq = 1'b1; else if (k > 1) rq = 1'b0;
      if (st) begin n_st++; if (st_first == 0) st_first = k; end
      if (rc) begin n_rc++; if (rc_first == 0) rc_first = k; end
      n_lo += lo; n_hi += hi; n_inh += inh;
    end
    wr = 0; rq = 0;
  endtask

  task automatic make_clean();
    fire(0, 0, 0, 1, 0, 0);
  endtask

  task automatic write_once();
    @(negedge clk); wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (RC + 2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R2: reset state and boot recall
    repeat (2) @(negedge clk);
    chk("R2", "recall_start in reset", int'(rc), 1);
    chk("R2", "inhibit in reset", int'(inh), 1);
    chk("R2", "pin drives in reset", int'(lo) + int'(hi), 0);
    chk("R2", "store_start in reset", int'(st), 0);
    rst_n = 1'b1;
    n_inh = 0;
    for (int k = 1; k <= WIN; k++) begin @(negedge clk); n_inh += inh; end
    chk("R2", "boot inhibit cycles after release", n_inh, RC - 1);
    // R2: dirty clear after boot: power-fail does nothing
    fire(1, 0, 0, 0, 0, 0);
    chk("R2", "no store when clean after boot", n_st, 0);

    // Sweep all trigger combinations with clean and dirty array
    for (int idx = 0; idx < 32; idx++) begin
      logic p, s, h, r, dty;
      int kind; // 0 none, 1 auto, 2 sw, 3 hw, 4 recall
      string tag;
      int e_first;
      p = idx[0]; s = idx[1]; h = idx[2]; r = idx[3]; dty = idx[4];
      make_clean();
      if (dty) write_once();
      fire(p, s, h, r, 0, 0);
      if (p)      begin kind = dty ? 1 : 0; tag = (s || h || r) ? "R11" : "R4"; end
      else if (s) begin kind = 2; tag = "R5"; end
      else if (h) begin kind = dty ? 3 : 0; tag = "R3"; end
      else if (r) begin kind = 4; tag = "R8"; end
      else        begin kind = 0; tag = "R10"; end
      e_first = (kind == 1 || kind == 2) ? 1 : (kind == 3) ? D + 1 : 0;
      chk(tag, "store_start count", n_st, (kind >= 1 && kind <= 3) ? 1 : 0);
      chk(tag, "store_start cycle", st_first, e_first);
      chk(tag, "recall_start cycle", rc_first, (kind == 4) ? 1 : 0);
      chk("R6", "pin low cycles", n_lo, (kind >= 1 && kind <= 3) ? SC : 0);
      chk("R7", "pin high cycles", n_hi, (kind == 2 || kind == 3) ? H : 0);
      chk("R1", "inhibit cycles", n_inh, (kind >= 1 && kind <= 3) ? SC : (kind == 4) ? RC : 0);
    end

    // R3: write during the pin delay makes the store go ahead
    make_clean();
    fire(0, 0, 1, 0, 2, 0);
    chk("R3", "store after write in delay", n_st, 1);
    chk("R3", "store cycle after write in delay", st_first, D + 1);

    // R1: write while inhibited is ignored; R8: store clears dirty
    make_clean();
    write_once();
    fire(0, 1, 0, 0, 3, 0);
    fire(1, 0, 0, 0, 0, 0);
    chk("R1", "write during store ignored", n_st, 0);

    // R10: recall request during a store is discarded
    make_clean();
    fire(0, 1, 0, 0, 0, 3);
    chk("R10", "recall during store", n_rc, 0);
    chk("R10", "store still ran", n_st, 1);

    // R8: recall clears dirty
    write_once();
    make_clean();
    fire(1, 0, 0, 0, 0, 0);
    chk("R8", "recall cleared dirty", n_st, 0);

    // R9: automatic store disabled by command
    @(negedge clk); aoff = 1'b1;
    @(negedge clk); aoff = 1'b0;
    write_once();
    fire(1, 0, 0, 0, 0, 0);
    chk("R9", "power-fail after disable", n_st, 0);
    fire(1, 1, 0, 0, 0, 0);
    chk("R9", "software store wins when auto off", n_st, 1);
    chk("R9", "hold after software store", n_hi, H);

    // R2: reset re-enables automatic storing
    do_reset();
    write_once();
    fire(1, 0, 0, 0, 0, 0);
    chk("R2", "auto store enabled after reset", n_st, 1);
    chk("R4", "no hold after auto store", n_hi, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule